// File: doc/BRIEF.md
# Pixel Output Formatter

This block is the last digital stage of an image-sensor front end. It receives each converted pixel code together with that pixel's preblank and black-clamp window flags, carries them through a fixed nine-stage pipeline, and presents the result on a parallel data word with a separate output-enable.

The pipeline advances once per active edge of a pixel data clock. That clock is sampled as a level on the system clock, and its active edge is selectable. At the end of the pipeline, a pixel flagged for blanking is replaced by either zero or the programmed black level. A pixel inside the clamp window is never replaced. The word can then be converted to Gray code before it reaches the output register.

The output register either loads only on data-clock edges (latched) or follows the pipeline every system clock (transparent). The output-enable lets the pad ring release the bus.

Top module: `opf_pixel_out`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, data_o is all zeros.
- R2: A pixel advance happens on the system clock edge at which pix_clk_i first equals cfg_clk_pol_i after not having equalled it. With cfg_clk_pol_i=1 that is a rising data-clock edge; with 0 it is a falling edge.
- R3: With cfg_transparent_i=0, the pixel sampled at advance N appears on data_o one system clock after advance N+9. data_o does not change between advances.
- R4: With cfg_transparent_i=1, data_o reloads on every system clock from the last pipeline stage. The pixel sampled at advance N is visible one clock after advance N+8, and format-setting changes show one clock later.
- R5: A pixel is marked for preblanking when preblank_i equals cfg_blank_pol_i at its advance.
- R6: With cfg_blank_to_lvl_i=0, a blanked pixel is output as all zeros.
- R7: With cfg_blank_to_lvl_i=1, a blanked pixel is output as cfg_clamp_lvl_i.
- R8: A pixel is inside the clamp window when clamp_win_i equals cfg_clamp_pol_i at its advance. Such a pixel is output as its own code, even if it is also marked for blanking.
- R9: The blank and clamp marks travel with their pixel through the same nine stages. A single blanked pixel replaces exactly that pixel's output word and no neighbour.
- R10: With cfg_gray_i=1 the output is v XOR (v >> 1), where v is the word after blank substitution. With 0 the output is v unchanged.
- R11: data_oe_o is the inverse of cfg_tristate_i in the same cycle. The three-state control does not alter data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk_i | input | 1 | Pixel data clock, sampled as a level |
| code_i | input | W | Converted pixel code |
| preblank_i | input | 1 | Preblank pulse |
| clamp_win_i | input | 1 | Black clamp window pulse |
| cfg_clk_pol_i | input | 1 | Active level of the data clock (1 high, 0 low) |
| cfg_blank_pol_i | input | 1 | Active level of the preblank pulse |
| cfg_clamp_pol_i | input | 1 | Active level of the clamp window |
| cfg_blank_to_lvl_i | input | 1 | Blank value: 0 zero, 1 clamp level |
| cfg_clamp_lvl_i | input | W | Black clamp level in output code units |
| cfg_gray_i | input | 1 | Output coding: 0 binary, 1 Gray |
| cfg_transparent_i | input | 1 | Output register: 0 latched on data clock, 1 transparent |
| cfg_tristate_i | input | 1 | 1 releases the data bus |
| data_o | output | W | Formatted pixel word |
| data_oe_o | output | 1 | Output-enable for the data pads |

## Verification
The bench goes after the following corner cases:
- **Falling-edge data clock.** A design that ignored the polarity bit would advance half a pixel early and shift every word.
- **Isolated blanked pixel.** A single blanked pixel between unblanked ones is checked against the exact output word. If the flags bypassed the pipeline, or were delayed by a different number of stages, blanking would land on a neighbouring word.
- **Blank and clamp together.** Pixels that carry both marks must emit their own code rather than the blank value.
- **Gray coding with blanking.** Gray coding is checked with blank-to-level enabled, where the Gray step must follow the substitution.
- **Transparent mode.** Switching coding in transparent mode must show up without waiting for a data-clock edge. A latched-mode design would lag by a whole pixel.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int unsigned OPF_CODE_W = 12;
  localparam int unsigned OPF_LAT    = 9;

  // per-pixel side marks carried next to the code
  typedef struct packed {
    logic blank;
    logic clamp;
  } opf_tag_t;
endpackage

// File: rtl/opf_edge.sv
module opf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic pol_i,
  output logic adv_o
);
  logic act_now;
  logic act_q;
  logic act_d;

  assign act_now = (lvl_i == pol_i);

  // reset as "already active" so no advance fires before a real edge
  always_comb begin
    act_d = act_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b1;
    else        act_q <= act_d;
  end

  assign adv_o = act_now & ~act_q;
endmodule

// File: rtl/opf_pipe.sv
module opf_pipe
  import opf_pkg::*;
#(
  parameter int unsigned W   = OPF_CODE_W,
  parameter int unsigned LAT = OPF_LAT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic [W-1:0] code_i,
  input  opf_tag_t     tag_i,
  output logic [W-1:0] code_o,
  output opf_tag_t     tag_o
);
  localparam int unsigned LAST = LAT - 1;

  logic [W-1:0] code_q [LAT];
  logic [W-1:0] code_d [LAT];
  opf_tag_t     tag_q  [LAT];
  opf_tag_t     tag_d  [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb begin
        code_d[g] = adv_i ? code_i : code_q[g];
        tag_d[g]  = adv_i ? tag_i  : tag_q[g];
      end
    end else begin : g_body
      always_comb begin
        code_d[g] = adv_i ? code_q[g-1] : code_q[g];
        tag_d[g]  = adv_i ? tag_q[g-1]  : tag_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[g] <= '0;
        tag_q[g]  <= '0;
      end else begin
        code_q[g] <= code_d[g];
        tag_q[g]  <= tag_d[g];
      end
    end
  end

  assign code_o = code_q[LAST];
  assign tag_o  = tag_q[LAST];
endmodule

// File: rtl/opf_fmt.sv
module opf_fmt
  import opf_pkg::*;
#(
  parameter int unsigned W = OPF_CODE_W
) (
  input  logic [W-1:0] code_i,
  input  opf_tag_t     tag_i,
  input  logic         blank_to_lvl_i,
  input  logic [W-1:0] lvl_i,
  input  logic         gray_i,
  output logic [W-1:0] word_o
);
  logic         kill;
  logic [W-1:0] subst;

  always_comb begin
    // clamp window wins over preblank
    kill  = tag_i.blank & ~tag_i.clamp;
    subst = code_i;
    if (kill) subst = blank_to_lvl_i ? lvl_i : '0;
    word_o = gray_i ? (subst ^ (subst >> 1)) : subst;
  end
endmodule

// File: rtl/opf_pixel_out.sv
module opf_pixel_out
  import opf_pkg::*;
#(
  parameter int unsigned W   = OPF_CODE_W,
  parameter int unsigned LAT = OPF_LAT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_clk_i,
  input  logic [W-1:0] code_i,
  input  logic         preblank_i,
  input  logic         clamp_win_i,
  input  logic         cfg_clk_pol_i,
  input  logic         cfg_blank_pol_i,
  input  logic         cfg_clamp_pol_i,
  input  logic         cfg_blank_to_lvl_i,
  input  logic [W-1:0] cfg_clamp_lvl_i,
  input  logic         cfg_gray_i,
  input  logic         cfg_transparent_i,
  input  logic         cfg_tristate_i,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic         adv;
  opf_tag_t     head_tag;
  opf_tag_t     tail_tag;
  logic [W-1:0] tail_code;
  logic         tail_blank;
  logic         tail_clamp;
  logic [W-1:0] fmt_word;
  logic         out_en;
  logic [W-1:0] out_d;
  logic [W-1:0] out_q;

  opf_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (pix_clk_i),
    .pol_i (cfg_clk_pol_i),
    .adv_o (adv)
  );

  always_comb begin
    head_tag.blank = (preblank_i  == cfg_blank_pol_i);
    head_tag.clamp = (clamp_win_i == cfg_clamp_pol_i);
  end

  opf_pipe #(.W(W), .LAT(LAT)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (adv),
    .code_i (code_i),
    .tag_i  (head_tag),
    .code_o (tail_code),
    .tag_o  (tail_tag)
  );

  assign tail_blank = tail_tag.blank;
  assign tail_clamp = tail_tag.clamp;

  opf_fmt #(.W(W)) u_fmt (
    .code_i         (tail_code),
    .tag_i          (tail_tag),
    .blank_to_lvl_i (cfg_blank_to_lvl_i),
    .lvl_i          (cfg_clamp_lvl_i),
    .gray_i         (cfg_gray_i),
    .word_o         (fmt_word)
  );

  // output register: data-clock enable when latched, free-running when transparent
  always_comb begin
    out_en = cfg_transparent_i | adv;
    out_d  = out_en ? fmt_word : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign data_o    = out_q;
  assign data_oe_o = ~cfg_tristate_i;
endmodule

// File: rtl/opf_pixel_out_chk.sv
module opf_pixel_out_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         adv,
  input logic         pix_clk_i,
  input logic         cfg_clk_pol_i,
  input logic         cfg_transparent_i,
  input logic         cfg_gray_i,
  input logic         cfg_blank_to_lvl_i,
  input logic [W-1:0] cfg_clamp_lvl_i,
  input logic [W-1:0] tail_code,
  input logic         tail_blank,
  input logic         tail_clamp,
  input logic [W-1:0] data_o
);
  // R2
  adv_on_active_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (pix_clk_i == cfg_clk_pol_i));

  // R2
  adv_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !adv);

  // R3
  latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_transparent_i && !adv) |=> $stable(data_o));

  // R6
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_transparent_i && adv && tail_blank && !tail_clamp && !cfg_blank_to_lvl_i)
      |=> (data_o == '0));

  // R7
  blank_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_transparent_i && adv && tail_blank && !tail_clamp && cfg_blank_to_lvl_i && !cfg_gray_i)
      |=> (data_o == $past(cfg_clamp_lvl_i)));

  // R8
  clamp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_transparent_i && adv && tail_clamp && !cfg_gray_i)
      |=> (data_o == $past(tail_code)));
endmodule

bind opf_pixel_out opf_pixel_out_chk #(.W(W)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .adv                (adv),
  .pix_clk_i          (pix_clk_i),
  .cfg_clk_pol_i      (cfg_clk_pol_i),
  .cfg_transparent_i  (cfg_transparent_i),
  .cfg_gray_i         (cfg_gray_i),
  .cfg_blank_to_lvl_i (cfg_blank_to_lvl_i),
  .cfg_clamp_lvl_i    (cfg_clamp_lvl_i),
  .tail_code          (tail_code),
  .tail_blank         (tail_blank),
  .tail_clamp         (tail_clamp),
  .data_o             (data_o)
);

// File: tb/sim_opf_pixel_out.sv
module sim_opf_pixel_out;
  localparam int W   = 12;
  localparam int LAT = 9;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pix_clk;
  logic [W-1:0] code;
  logic         pblank, cwin;
  logic         c_clk_pol, c_blank_pol, c_clamp_pol, c_to_lvl, c_gray, c_transp, c_tri;
  logic [W-1:0] c_lvl;
  logic [W-1:0] data_o;
  logic         data_oe;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string phase  = "R1";

  // reference state
  logic [W-1:0] m_code [$];
  bit           m_blk  [$];
  bit           m_clp  [$];
  bit           m_act;
  logic [W-1:0] m_out;

  always #5 clk = ~clk;

  opf_pixel_out #(.W(W), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_clk_i(pix_clk), .code_i(code),
    .preblank_i(pblank), .clamp_win_i(cwin),
    .cfg_clk_pol_i(c_clk_pol), .cfg_blank_pol_i(c_blank_pol), .cfg_clamp_pol_i(c_clamp_pol),
    .cfg_blank_to_lvl_i(c_to_lvl), .cfg_clamp_lvl_i(c_lvl), .cfg_gray_i(c_gray),
    .cfg_transparent_i(c_transp), .cfg_tristate_i(c_tri),
    .data_o(data_o), .data_oe_o(data_oe)
  );

  task automatic model_reset();
    m_code.delete(); m_blk.delete(); m_clp.delete();
    for (int i = 0; i < LAT; i++) begin
      m_code.push_back('0); m_blk.push_back(0); m_clp.push_back(0);
    end
    m_act = 1;
    m_out = '0;
  endtask

  // one system clock edge of the behavioural reference
  task automatic model_edge();
    bit           act, adv;
    logic [W-1:0] v;
    if (!rst_n) begin model_reset(); return; end
    act = (pix_clk == c_clk_pol);
    adv = act && !m_act;
    m_act = act;
    v = m_code[LAT-1];
    if (m_blk[LAT-1] && !m_clp[LAT-1]) v = c_to_lvl ? c_lvl : '0;
    if (c_gray) v = v ^ (v >> 1);
    if (c_transp || adv) m_out = v;
    if (adv) begin
      m_code.push_front(code);
      m_blk.push_front(pblank == c_blank_pol);
      m_clp.push_front(cwin == c_clamp_pol);
      void'(m_code.pop_back()); void'(m_blk.pop_back()); void'(m_clp.pop_back());
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_edge();
    n_chk++;
    if (data_o !== m_out) begin
      n_fail++;
      $display("FAIL %s data_o actual=%h expected=%h", phase, data_o, m_out);
    end
    n_chk++;
    if (data_oe !== !c_tri) begin
      n_fail++;
      $display("FAIL R11 data_oe_o actual=%b expected=%b", data_oe, !c_tri);
    end
  endtask

  task automatic pixel(input logic [W-1:0] c, input logic b, input logic k);
    code = c; pblank = b; cwin = k;
    pix_clk = ~c_clk_pol;
    tick(); tick();
    pix_clk = c_clk_pol;
    tick(); tick();
  endtask

  // idle pixel: preblank and clamp both inactive
  task automatic flush(input int n);
    for (int i = 0; i < n; i++) pixel(W'($urandom), ~c_blank_pol, ~c_clamp_pol);
  endtask

  initial begin
    rst_n = 0; pix_clk = 0; code = '0; pblank = 0; cwin = 0;
    c_clk_pol = 1; c_blank_pol = 1; c_clamp_pol = 1; c_to_lvl = 0; c_gray = 0;
    c_transp = 0; c_tri = 0; c_lvl = 12'h040;
    model_reset();
    repeat (3) tick();
    n_chk++;
    if (data_o !== '0) begin  // R1
      n_fail++;
      $display("FAIL R1 reset data_o actual=%h expected=000", data_o);
    end
    rst_n = 1;
    tick();

    phase = "R3";  // rising data clock, binary, latched
    flush(24);

    phase = "R2";  // falling data clock
    c_clk_pol = 0;
    flush(20);

    phase = "R5";  // preblank active low
    c_blank_pol = 0;
    for (int i = 0; i < 20; i++) pixel(W'($urandom), 1'($urandom), ~c_clamp_pol);
    flush(10);

    phase = "R6";  // preblank active high, blank to zero
    c_blank_pol = 1;
    for (int i = 0; i < 20; i++) pixel(W'($urandom), 1'($urandom), ~c_clamp_pol);
    flush(10);

    phase = "R7";  // blank to clamp level
    c_to_lvl = 1; c_lvl = 12'h0A5;
    for (int i = 0; i < 20; i++) pixel(W'($urandom), 1'($urandom), ~c_clamp_pol);
    flush(10);

    phase = "R8";  // clamp window overrides blank, clamp active low
    c_clamp_pol = 0;
    for (int i = 0; i < 24; i++) pixel(W'($urandom), 1'($urandom), 1'($urandom));
    flush(10);

    phase = "R9";  // single blanked pixel alignment
    c_to_lvl = 0;
    flush(5);
    pixel(12'hFFF, c_blank_pol, ~c_clamp_pol);
    flush(12);

    phase = "R10"; // gray coding after substitution
    c_gray = 1; c_to_lvl = 1; c_lvl = 12'h3C7;
    for (int i = 0; i < 24; i++) pixel(W'($urandom), 1'($urandom), 1'($urandom));
    flush(10);

    phase = "R4";  // transparent output register, coding changes mid-pixel
    c_transp = 1;
    for (int i = 0; i < 12; i++) begin
      pixel(W'($urandom), 1'($urandom), ~c_clamp_pol);
      c_gray = ~c_gray;
      tick();
    end
    flush(10);
    c_transp = 0;
    flush(4);

    phase = "R11"; // three-state toggling does not disturb data
    for (int i = 0; i < 12; i++) begin
      c_tri = 1'($urandom);
      pixel(W'($urandom), ~c_blank_pol, ~c_clamp_pol);
    end
    c_tri = 0;
    flush(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule